// File: doc/BRIEF.md
# Synchronous Transfer Interrupt Controller

This block lets a microcontroller time its accesses to per-channel data registers that are exchanged on a time-division serial frame. It follows the frame from a data clock and a frame sync. Two data-clock periods make one bit-clock period, and eight bit-clock periods make one time slot. For each of four channel sources it raises a transfer interrupt at a programmable slot. If software does not acknowledge that interrupt before a second, separately programmed deadline slot, it raises an overflow interrupt.

Each source has a configuration word with three fields: a transfer slot, a deadline slot and a position bit. The position bit moves both the interrupt point and the deadline by one bit-clock period. Software can mask sources, acknowledge interrupts and read a status byte. A read clears the status byte. A single active-high interrupt line summarises every unmasked pending bit.

Top module: `sync_xfer_irq`

## Requirements
- R1: A rising `dcl` edge with `fsc` high starts bit period 0. After that, every second rising `dcl` edge starts the next bit period. A new frame sync restarts the count from 0 at any point.
- R2: Source s (index 0..3, chosen by `cfgSel`; `cfgData` = {pos[10], deadline slot[9:5], transfer slot[4:0]}) sets status bit s when bit period 8·slot+9 starts (pos=0) or when bit period 8·slot+8 starts (pos=1).
- R3: The deadline of source s is the start of bit period 8·deadline−1 (pos=0) or 8·deadline (pos=1). If a transfer interrupt was raised and was not acknowledged by then, status bit 4+s is set.
- R4: Writing 1 to bit s of `ackData` with `ackWe` before the deadline starts prevents the overflow. A write after the deadline has started does not. The acknowledge clears itself when source s next raises its transfer interrupt.
- R5: While bit s of the mask register is 1, source s sets neither its transfer bit nor its overflow bit.
- R6: A cycle with `staRe` high returns the current status byte on `staData` and clears every status bit.
- R7: When a read and a new interrupt event fall in the same clock cycle, the new bit stays set after the read.
- R8: `stIrq` is high exactly when a status bit of an unmasked source is set. A pending bit whose source is masked later does not drive `stIrq`, but it can still be read.
- R9: After reset the status byte, the mask and `stIrq` are all 0. Sources raise their interrupts independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dcl | input | 1 | Serial data clock, sampled |
| fsc | input | 1 | Frame sync, sampled on rising dcl |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Source selected for configuration |
| cfgData | input | 11 | {pos, deadline slot, transfer slot} |
| mskWe | input | 1 | Mask write strobe |
| mskData | input | 4 | Mask value, 1 masks a source |
| ackWe | input | 1 | Acknowledge write strobe |
| ackData | input | 4 | 1 acknowledges a source |
| staRe | input | 1 | Status read strobe, clears status |
| staData | output | 8 | {overflow[3:0], transfer[3:0]} |
| stIrq | output | 1 | Summary interrupt, active high |

## Verification
A clear-on-read and the setting of a new transfer bit can fall in the same clock cycle. The bench provokes this by asserting the read strobe in exactly the cycle in which the sampled rising data-clock edge reaches the target bit period. It expects the read to return the old byte, and it expects a second read to return the new bit. The acknowledge deadline is checked on both sides of the boundary: an acknowledge during the last bit period before the deadline must prevent the overflow, and an acknowledge just after the deadline must not.

// File: rtl/sync_xfer_irq_pkg.sv
package sync_xfer_irq_pkg;
  localparam int SRC_N = 4;
  localparam int SEL_W = $clog2(SRC_N);

  typedef struct packed {
    logic [SRC_N-1:0] stiRaise;
    logic [SRC_N-1:0] ovCheck;
  } hitStrobes_t;
endpackage

// File: rtl/sxi_ctrl.sv
module sxi_ctrl
  import sync_xfer_irq_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dcl,
  input  logic                          fsc,
  input  logic [SRC_N-1:0][SLOT_W-1:0]  stiSlot,
  input  logic [SRC_N-1:0][SLOT_W-1:0]  ovSlot,
  input  logic [SRC_N-1:0]              dps,
  input  logic [SRC_N-1:0]              msk,
  output hitStrobes_t                   hits
);
  localparam int POS_W = SLOT_W + 4;

  logic dclQ, dclQQ, fscQ, halfQ;
  logic dclRise, bclTick;
  logic [POS_W-1:0] posQ, posNext;
  logic [SRC_N-1:0] stiRaise, ovCheck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dclQ  <= 1'b0;
      dclQQ <= 1'b0;
      fscQ  <= 1'b0;
    end else begin
      dclQ  <= dcl;
      dclQQ <= dclQ;
      fscQ  <= fsc;
    end
  end

  // a bit period starts on a frame sync or on every other data clock rise
  assign dclRise = dclQ & ~dclQQ;
  assign bclTick = dclRise & (fscQ | ~halfQ);
  assign posNext = fscQ ? '0 : posQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ  <= '0;
      halfQ <= 1'b0;
    end else begin
      if (bclTick) posQ <= posNext;
      if (dclRise) halfQ <= bclTick;
    end
  end

  for (genvar i = 0; i < SRC_N; i++) begin : gSrc
    logic [POS_W-1:0] stiPos, ovPos, slotBase, ovBase;
    assign slotBase = POS_W'({stiSlot[i], 3'b000});
    assign ovBase   = POS_W'({ovSlot[i], 3'b000});
    assign stiPos   = slotBase + (dps[i] ? POS_W'(8) : POS_W'(9));
    assign ovPos    = ovBase - (dps[i] ? POS_W'(0) : POS_W'(1));
    assign stiRaise[i] = bclTick & (posNext == stiPos) & ~msk[i];
    assign ovCheck[i]  = bclTick & (posNext == ovPos) & ~msk[i];
  end

  assign hits = '{stiRaise: stiRaise, ovCheck: ovCheck};
endmodule

// File: rtl/sxi_regs.sv
module sxi_regs
  import sync_xfer_irq_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWe,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [2*SLOT_W:0]             cfgData,
  input  logic                          mskWe,
  input  logic [SRC_N-1:0]              mskData,
  input  logic                          ackWe,
  input  logic [SRC_N-1:0]              ackData,
  input  logic                          staRe,
  input  hitStrobes_t                   hits,
  output logic [SRC_N-1:0][SLOT_W-1:0]  stiSlot,
  output logic [SRC_N-1:0][SLOT_W-1:0]  ovSlot,
  output logic [SRC_N-1:0]              dps,
  output logic [SRC_N-1:0]              msk,
  output logic [2*SRC_N-1:0]            staData,
  output logic                          stIrq
);
  logic [SRC_N-1:0] ackQ, armQ, stiQ, stovQ, ovSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stiSlot <= '0;
      ovSlot  <= '0;
      dps     <= '0;
      msk     <= '0;
    end else begin
      if (cfgWe) begin
        stiSlot[cfgSel] <= cfgData[SLOT_W-1:0];
        ovSlot[cfgSel]  <= cfgData[2*SLOT_W-1:SLOT_W];
        dps[cfgSel]     <= cfgData[2*SLOT_W];
      end
      if (mskWe) msk <= mskData;
    end
  end

  assign ovSet = hits.ovCheck & armQ & ~ackQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ <= '0;
      armQ <= '0;
    end else begin
      for (int i = 0; i < SRC_N; i++) begin
        if (hits.stiRaise[i]) begin
          ackQ[i] <= 1'b0;
          armQ[i] <= 1'b1;
        end else begin
          if (ackWe && ackData[i]) ackQ[i] <= 1'b1;
          if (hits.ovCheck[i]) armQ[i] <= 1'b0;
        end
      end
    end
  end

  // a new event outranks the clear of a simultaneous read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stiQ  <= '0;
      stovQ <= '0;
    end else begin
      stiQ  <= (staRe ? '0 : stiQ)  | hits.stiRaise;
      stovQ <= (staRe ? '0 : stovQ) | ovSet;
    end
  end

  assign staData = {stovQ, stiQ};
  assign stIrq   = |((stiQ | stovQ) & ~msk);
endmodule

// File: rtl/sync_xfer_irq.sv
module sync_xfer_irq
  import sync_xfer_irq_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dcl,
  input  logic                 fsc,
  input  logic                 cfgWe,
  input  logic [SEL_W-1:0]     cfgSel,
  input  logic [2*SLOT_W:0]    cfgData,
  input  logic                 mskWe,
  input  logic [SRC_N-1:0]     mskData,
  input  logic                 ackWe,
  input  logic [SRC_N-1:0]     ackData,
  input  logic                 staRe,
  output logic [2*SRC_N-1:0]   staData,
  output logic                 stIrq
);
  logic [SRC_N-1:0][SLOT_W-1:0] stiSlot, ovSlot;
  logic [SRC_N-1:0] dps, mskQ;
  hitStrobes_t hits;

  sxi_ctrl #(.SLOT_W(SLOT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dcl(dcl), .fsc(fsc),
    .stiSlot(stiSlot), .ovSlot(ovSlot), .dps(dps), .msk(mskQ),
    .hits(hits)
  );

  sxi_regs #(.SLOT_W(SLOT_W)) uRegs (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .mskWe(mskWe), .mskData(mskData),
    .ackWe(ackWe), .ackData(ackData),
    .staRe(staRe), .hits(hits),
    .stiSlot(stiSlot), .ovSlot(ovSlot), .dps(dps), .msk(mskQ),
    .staData(staData), .stIrq(stIrq)
  );
endmodule

// File: rtl/sxi_checker.sv
module sxi_checker
  import sync_xfer_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                staRe,
  input logic [2*SRC_N-1:0]  staData,
  input logic                stIrq,
  input hitStrobes_t         hits,
  input logic [SRC_N-1:0]    msk
);
  // R6: a read with no event in the same cycle empties the status
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (staRe && hits == '0) |=> (staData == '0));

  // R5: bits that newly appear belong only to sources unmasked before the edge
  a_r5_masked_no_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((staData & ~$past(staData)) & {$past(msk), $past(msk)}) == '0));

  // R8: no pending unmasked bit means no interrupt
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((staData & {~msk, ~msk}) == '0) |-> !stIrq);

  for (genvar i = 0; i < SRC_N; i++) begin : gChk
    // R2 and R7: a raise is visible next cycle even during a read
    a_r7_raise_survives: assert property (@(posedge clk) disable iff (!rstN)
      hits.stiRaise[i] |=> staData[i]);
  end
endmodule

bind sync_xfer_irq sxi_checker uChk (
  .clk(clk), .rstN(rstN), .staRe(staRe), .staData(staData),
  .stIrq(stIrq), .hits(hits), .msk(mskQ)
);

// File: tb/sync_xfer_irq_test.sv
`timescale 1ns/1ps
module sync_xfer_irq_test;
  logic clk = 1'b0, rstN = 1'b0, dcl = 1'b0, fsc = 1'b0;
  logic cfgWe = 1'b0, mskWe = 1'b0, ackWe = 1'b0, staRe = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [10:0] cfgData = '0;
  logic [3:0] mskData = '0, ackData = '0;
  logic [7:0] staData;
  logic stIrq;

  int checks = 0, errors = 0, pos = 0;
  bit done = 0;
  string tagQ[$];
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  sync_xfer_irq uut (
    .clk(clk), .rstN(rstN), .dcl(dcl), .fsc(fsc),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .mskWe(mskWe), .mskData(mskData), .ackWe(ackWe), .ackData(ackData),
    .staRe(staRe), .staData(staData), .stIrq(stIrq)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares each read against the next expected item
  initial forever begin
    @(negedge clk); #1;
    if (staRe) begin
      string t;
      logic [7:0] e;
      t = tagQ.pop_front();
      e = expQ.pop_front();
      checks++;
      if (staData !== e) begin
        errors++;
        $display("FAIL %s status got %h expected %h", t, staData, e);
      end
    end
  end

  task automatic pushExp(string t, logic [7:0] v);
    tagQ.push_back(t);
    expQ.push_back(v);
  endtask

  task automatic rd(string t, logic [7:0] v);
    @(negedge clk); pushExp(t, v); staRe = 1;
    @(negedge clk); staRe = 0;
  endtask

  task automatic chkIrq(string t, logic v);
    @(negedge clk); #1;
    checks++;
    if (stIrq !== v) begin
      errors++;
      $display("FAIL %s stIrq got %b expected %b", t, stIrq, v);
    end
  endtask

  task automatic cfg(int s, bit p, int ov, int st);
    @(negedge clk); cfgWe = 1; cfgSel = 2'(s); cfgData = {p, 5'(ov), 5'(st)};
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic setMask(logic [3:0] m);
    @(negedge clk); mskWe = 1; mskData = m;
    @(negedge clk); mskWe = 0;
  endtask

  task automatic ack(logic [3:0] a);
    @(negedge clk); ackWe = 1; ackData = a;
    @(negedge clk); ackWe = 0;
  endtask

  // one data clock period; optional read in the cycle the edge is acted on
  task automatic dclCycle(bit f, bit collide, logic [7:0] oldVal);
    @(negedge clk); dcl = 1; fsc = f;
    @(negedge clk); if (collide) begin pushExp("R7 collide", oldVal); staRe = 1; end
    @(negedge clk); staRe = 0; fsc = 0; dcl = 0;
    @(negedge clk);
  endtask

  task automatic bcl(bit f, bit collide, logic [7:0] oldVal);
    dclCycle(f, collide, oldVal);
    dclCycle(0, 0, 8'h00);
    pos = f ? 0 : pos + 1;
  endtask

  task automatic startFrame(); bcl(1, 0, 8'h00); endtask
  task automatic advanceTo(int p); while (pos < p) bcl(0, 0, 8'h00); endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // R9 reset state
    rd("R9 reset", 8'h00);
    chkIrq("R9 reset irq", 0);

    // frame A: source 0, slot 1, pos 0, deadline slot 4 -> raise 17, deadline 31
    cfg(0, 0, 4, 1);
    setMask(4'b1110);
    startFrame();
    advanceTo(16);
    chkIrq("R2 not early", 0);
    advanceTo(17);
    chkIrq("R8 irq on raise", 1);
    rd("R2 raise src0", 8'h01);
    chkIrq("R6 irq after read", 0);
    advanceTo(30);
    rd("R3 no early overflow", 8'h00);
    advanceTo(31);
    rd("R3 overflow src0", 8'h10);

    // frame B: source 1, pos 1 -> raise 16, deadline 32; read collides at 16
    cfg(1, 1, 4, 1);
    setMask(4'b1100);
    startFrame();
    advanceTo(15);
    bcl(0, 1, 8'h00);
    rd("R7 bit survives", 8'h02);
    advanceTo(17);
    rd("R9 src0 alone", 8'h01);
    advanceTo(30);
    ack(4'b0001);
    advanceTo(31);
    ack(4'b0010);
    advanceTo(32);
    rd("R4 acks in time", 8'h00);

    // frame C: acks self-cleared, late ack for source 0
    startFrame();
    advanceTo(17);
    rd("R9 both raised", 8'h03);
    advanceTo(31);
    ack(4'b0001);
    rd("R4 late ack", 8'h10);
    advanceTo(32);
    rd("R4 ack self-cleared", 8'h20);

    // frame D: source 2 masked; mask applied to pending bits
    cfg(2, 0, 5, 2);
    startFrame();
    advanceTo(17);
    chkIrq("R8 pending irq", 1);
    setMask(4'b1111);
    chkIrq("R8 masked irq", 0);
    rd("R8 bits readable", 8'h03);
    advanceTo(40);
    rd("R5 masked no bits", 8'h00);

    // frame E: resync mid-frame
    setMask(4'b1110);
    startFrame();
    advanceTo(10);
    startFrame();
    advanceTo(16);
    rd("R1 resync no raise", 8'h00);
    advanceTo(17);
    rd("R1 resync raise", 8'h01);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule